// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit forms the memory address that a load, store or branch will use. The decode stage hands it a 3-bit addressing mode with the values it may need: two register values, a 16-bit signed constant, a full-width address field from the instruction and the program counter. On a start strobe the unit selects the mode's formula and returns the address with a one-cycle done pulse.

Most modes finish one cycle after start. The memory-indirect mode is the exception. It first reads memory at the pointer held in the first register, waits for the read data, and then presents that word as the final address. Two modes name an operand rather than a location: the immediate mode and the register-operand mode. For these the unit still completes, but it raises a no-address flag and drives the address to zero. All arithmetic wraps modulo 2^32.

Top module: `eag_top`

## Requirements
- R1: While reset is low and in the cycle after it is released, `done`, `no_addr` and `mem_rd_req` are 0 and `ea` is zero.
- R2: With mode 0 (direct), `done` is 1 in the cycle after an accepted start, and `ea` equals `addr_fld`.
- R3: With mode 1 (register-direct), `ea` equals `reg_a` when `done` is 1.
- R4: With mode 2 (base plus displacement), `ea` equals `reg_a` plus `disp` sign-extended from bit 15, modulo 2^32.
- R5: With mode 3 (register plus register), `ea` equals `reg_a` plus `reg_b`, modulo 2^32.
- R6: With mode 4 (indirect), in the cycle after start `mem_rd_req` is 1 and `mem_rd_addr` equals the `reg_a` sampled at start. Both hold unchanged, with `done` at 0, until `mem_rd_valid` is sampled high.
- R7: In indirect mode, the cycle after `mem_rd_valid` is sampled high with `mem_rd_req` at 1, `done` is 1, `ea` equals the sampled `mem_rd_data` and `mem_rd_req` is 0.
- R8: With mode 5 (PC-relative), `ea` equals `pc` plus `disp` sign-extended from bit 15, modulo 2^32.
- R9: With mode 6 (immediate) or mode 7 (register operand), `done` comes with `no_addr` at 1 and `ea` at zero. Modes 0 to 5 complete with `no_addr` at 0.
- R10: `done` is 1 for exactly one cycle per accepted start. A start seen while an indirect read is pending is ignored: it produces no `done` and does not change the pending read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address calculation |
| mode | input | 3 | Addressing mode, 0..7 as in R2 to R9 |
| reg_a | input | 32 | First register value (base, pointer, or index) |
| reg_b | input | 32 | Second register value (register plus register mode) |
| disp | input | 16 | Signed constant from the instruction |
| addr_fld | input | 32 | Full address field for direct mode |
| pc | input | 32 | Program counter |
| mem_rd_req | output | 1 | Indirect pointer read request, held until data is valid |
| mem_rd_addr | output | 32 | Address of the pointer read |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Read data (the final address in indirect mode) |
| ea | output | 32 | Effective address, valid when done is 1 |
| done | output | 1 | One-cycle completion pulse |
| no_addr | output | 1 | The mode names an operand, not a memory location |

## Verification
The bench uses negative constants and operand pairs whose sums carry past bit 31. A design that zero-extends the constant or drops the carry gives a wrong address for backward branches and wrapped bases. In indirect mode it holds read data back for several cycles. During that wait it issues a second start, and then returns the data on the first requested cycle. A design that finishes early, accepts the stray start or forwards the pointer instead of the read word would show a premature or extra `done` or the wrong `ea`. The operand-only modes are driven with non-zero register values, which exposes a design that leaks the register onto `ea` or leaves `no_addr` clear. A reset applied mid-read must drop the pending request.

// File: rtl/eag_pkg.sv
// Package: shared mode encoding for the effective address generator.
// Assumes the decode stage supplies the 3-bit mode field in this encoding.
package eag_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REGDIR   = 3'd1,
        AM_BASEDISP = 3'd2,
        AM_REGREG   = 3'd3,
        AM_INDIRECT = 3'd4,
        AM_PCREL    = 3'd5,
        AM_IMM      = 3'd6,
        AM_REGOP    = 3'd7
    } amode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } eag_state_e;
endpackage

// File: rtl/eag_calc.sv
// Module: eag_calc
// Combinational address formation for every mode that needs no memory read.
// A single adder serves base+displacement, register+register and PC-relative.
// Its operands are steered by the mode.
// Assumes: DISP_W <= ADDR_W or the constant is truncated; sums wrap.
module eag_calc #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] reg_a,
    input  logic [ADDR_W-1:0] reg_b,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr_c,
    output logic              no_addr_c,
    output logic              need_mem
);
    import eag_pkg::*;

    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] op_x;
    logic [ADDR_W-1:0] op_y;
    logic [ADDR_W-1:0] sum;
    amode_e            am;

    assign am = amode_e'(mode);

    // Sign extension of the constant; the variant depends on the widths.
    generate
        if (DISP_W < ADDR_W) begin : g_ext
            localparam int EXT_W = ADDR_W - DISP_W;
            assign disp_x = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_x = disp[ADDR_W-1:0];
        end
    endgenerate

    // Operand steering for the shared adder.
    always_comb begin
        op_x = (am == AM_PCREL) ? pc : reg_a;
        op_y = (am == AM_REGREG) ? reg_b : disp_x;
    end

    assign sum = op_x + op_y;

    // Final selection of the address and the mode flags.
    always_comb begin
        addr_c    = '0;
        no_addr_c = 1'b0;
        need_mem  = 1'b0;
        unique case (am)
            AM_DIRECT:   addr_c = addr_fld;
            AM_REGDIR:   addr_c = reg_a;
            AM_BASEDISP: addr_c = sum;
            AM_REGREG:   addr_c = sum;
            AM_PCREL:    addr_c = sum;
            AM_INDIRECT: need_mem = 1'b1;
            AM_IMM,
            AM_REGOP:    no_addr_c = 1'b1;
            default:     addr_c = '0;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
// Module: eag_seq
// Sequencer and output registers. Single-cycle modes complete on the edge
// after start. Indirect mode issues a held read request and completes on the
// edge after valid data is sampled.
// Assumes: memory holds data stable only while valid is high.
module eag_seq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              need_mem,
    input  logic              no_addr_c,
    input  logic [ADDR_W-1:0] addr_c,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [ADDR_W-1:0] ea,
    output logic              done,
    output logic              no_addr
);
    import eag_pkg::*;

    eag_state_e state;

    // State machine and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            ea          <= '0;
            done        <= 1'b0;
            no_addr     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (need_mem) begin
                            state       <= ST_WAIT;
                            mem_rd_req  <= 1'b1;
                            mem_rd_addr <= ptr;
                        end else begin
                            done    <= 1'b1;
                            ea      <= addr_c;
                            no_addr <= no_addr_c;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        state      <= ST_IDLE;
                        mem_rd_req <= 1'b0;
                        done       <= 1'b1;
                        ea         <= mem_rd_data;
                        no_addr    <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eag_top.sv
// Module: eag_top
// Effective address generator for six address modes plus two operand-only
// modes. Combinational formation feeds a small sequencer that also handles
// the one-level memory-indirect lookup.
// Assumes: start is a request held for one cycle; it is ignored while an
// indirect read is pending.
module eag_top #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] reg_a,
    input  logic [ADDR_W-1:0] reg_b,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic [ADDR_W-1:0] pc,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic [ADDR_W-1:0] ea,
    output logic              done,
    output logic              no_addr
);
    logic [ADDR_W-1:0] addr_c;
    logic              no_addr_c;
    logic              need_mem;

    eag_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
        .mode      (mode),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .disp      (disp),
        .addr_fld  (addr_fld),
        .pc        (pc),
        .addr_c    (addr_c),
        .no_addr_c (no_addr_c),
        .need_mem  (need_mem)
    );

    eag_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .need_mem     (need_mem),
        .no_addr_c    (no_addr_c),
        .addr_c       (addr_c),
        .ptr          (reg_a),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .ea           (ea),
        .done         (done),
        .no_addr      (no_addr)
    );
endmodule

// File: rtl/eag_chk.sv
// Module: eag_chk
// Protocol and timing properties of eag_top, observed at its ports.
// Attached to every eag_top instance by the bind at the end of this file.
module eag_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        mode,
    input logic [ADDR_W-1:0] reg_a,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_data,
    input logic [ADDR_W-1:0] ea,
    input logic              done,
    input logic              no_addr
);
    // R2: a start accepted in a single-cycle mode completes on the next cycle
    a_r2_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd_req && mode != 3'd4) |=> (done && !mem_rd_req));

    // R6: indirect start raises the read request at the pointer value
    a_r6_req_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd_req && mode == 3'd4)
        |=> (mem_rd_req && !done && mem_rd_addr == $past(reg_a)));

    // R6: the pending request holds until data arrives
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid)
        |=> (mem_rd_req && !done && $stable(mem_rd_addr)));

    // R7: read data becomes the address one cycle after valid
    a_r7_indirect_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid)
        |=> (done && !mem_rd_req && !no_addr && ea == $past(mem_rd_data)));

    // R9: the operand-only flag forces a zero address
    a_r9_noaddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_addr) |-> (ea == '0));

    // R10: no completion without an accepted start or returning read
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !((start && !mem_rd_req) || (mem_rd_req && mem_rd_valid)) |=> !done);
endmodule

bind eag_top eag_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode         (mode),
    .reg_a        (reg_a),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .ea           (ea),
    .done         (done),
    .no_addr      (no_addr)
);

// File: tb/eag_top_tb.sv
module eag_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    typedef struct packed {
        logic [2:0]  mode;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] d;
        logic [31:0] fld;
        logic [31:0] pc;
        logic [31:0] exp_ea;
        logic        exp_na;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VTAB [NV] = '{
        '{3'd0, 32'h0, 32'h0, 16'h0, 32'h0000_1234, 32'h0, 32'h0000_1234, 1'b0}, // R2
        '{3'd1, 32'hDEAD_BEEF, 32'h0, 16'h0, 32'h5, 32'h0, 32'hDEAD_BEEF, 1'b0}, // R3
        '{3'd2, 32'h0000_1000, 32'h0, 16'h0010, 32'h0, 32'h0, 32'h0000_1010, 1'b0}, // R4
        '{3'd2, 32'h0000_1000, 32'h0, 16'hFFF0, 32'h0, 32'h0, 32'h0000_0FF0, 1'b0}, // R4 negative
        '{3'd2, 32'hFFFF_FFF0, 32'h0, 16'h0020, 32'h0, 32'h0, 32'h0000_0010, 1'b0}, // R4 wrap
        '{3'd3, 32'h1111_0000, 32'h0000_2222, 16'hFFFF, 32'h0, 32'h0, 32'h1111_2222, 1'b0}, // R5
        '{3'd3, 32'h8000_0000, 32'h8000_0001, 16'h0, 32'h0, 32'h0, 32'h0000_0001, 1'b0}, // R5 wrap
        '{3'd5, 32'h7, 32'h0, 16'h0008, 32'h0, 32'h0000_0400, 32'h0000_0408, 1'b0}, // R8
        '{3'd5, 32'h0, 32'h0, 16'hFFFC, 32'h0, 32'h0000_0400, 32'h0000_03FC, 1'b0}, // R8 backward
        '{3'd5, 32'h0, 32'h0, 16'hFFF8, 32'h0, 32'h0000_0004, 32'hFFFF_FFFC, 1'b0}, // R8 wrap
        '{3'd6, 32'h1234_5678, 32'h9, 16'h7777, 32'hAAAA, 32'h44, 32'h0, 1'b1}, // R9
        '{3'd7, 32'hFFFF_FFFF, 32'h9, 16'h1, 32'hBBBB, 32'h44, 32'h0, 1'b1}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] reg_a = '0;
    logic [31:0] reg_b = '0;
    logic [15:0] disp = '0;
    logic [31:0] addr_fld = '0;
    logic [31:0] pc = '0;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [31:0] ea;
    logic        done;
    logic        no_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    eag_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode         (mode),
        .reg_a        (reg_a),
        .reg_b        (reg_b),
        .disp         (disp),
        .addr_fld     (addr_fld),
        .pc           (pc),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .ea           (ea),
        .done         (done),
        .no_addr      (no_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG_LIMIT);
            finish_run();
        end
    end

    task automatic drive(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] d, input logic [31:0] f, input logic [31:0] p);
        mode = m; reg_a = a; reg_b = b; disp = d; addr_fld = f; pc = p;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 req", {31'b0, mem_rd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ea", ea, 32'd0);
        check("R1 no_addr", {31'b0, no_addr}, 32'd0);

        // Table walk: single-cycle modes R2 R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            drive(VTAB[i].mode, VTAB[i].a, VTAB[i].b, VTAB[i].d, VTAB[i].fld, VTAB[i].pc);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check($sformatf("vec%0d done R2", i), {31'b0, done}, 32'd1);
            check($sformatf("vec%0d ea mode %0d", i, VTAB[i].mode), ea, VTAB[i].exp_ea);
            check($sformatf("vec%0d no_addr R9", i), {31'b0, no_addr}, {31'b0, VTAB[i].exp_na});
            @(negedge clk);
            check($sformatf("vec%0d pulse R10", i), {31'b0, done}, 32'd0);
        end

        // R6 R7 R10: indirect with a delayed read and a stray start
        drive(3'd4, 32'h0000_2000, 32'h0, 16'h0, 32'h0, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 req", {31'b0, mem_rd_req}, 32'd1);
        check("R6 addr", mem_rd_addr, 32'h0000_2000);
        check("R6 no done", {31'b0, done}, 32'd0);
        drive(3'd0, 32'h0000_9999, 32'h0, 16'h0, 32'h0000_5555, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 stray start ignored", {31'b0, done}, 32'd0);
        check("R6 addr stable", mem_rd_addr, 32'h0000_2000);
        repeat (2) @(negedge clk);
        check("R6 still pending", {31'b0, mem_rd_req}, 32'd1);
        check("R10 no done", {31'b0, done}, 32'd0);
        mem_rd_valid = 1'b1;
        mem_rd_data  = 32'hABCD_0123;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data  = 32'h0;
        check("R7 done", {31'b0, done}, 32'd1);
        check("R7 ea", ea, 32'hABCD_0123);
        check("R7 req drop", {31'b0, mem_rd_req}, 32'd0);
        check("R7 no_addr", {31'b0, no_addr}, 32'd0);
        @(negedge clk);
        check("R10 indirect pulse", {31'b0, done}, 32'd0);

        // R7: data valid on the first requested cycle
        drive(3'd4, 32'h0000_0040, 32'h0, 16'h0, 32'h0, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mem_rd_valid = 1'b1;
        mem_rd_data  = 32'h0BAD_F00D;
        check("R6 fast addr", mem_rd_addr, 32'h0000_0040);
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R7 fast done", {31'b0, done}, 32'd1);
        check("R7 fast ea", ea, 32'h0BAD_F00D);

        // R10: back-to-back starts each complete once
        drive(3'd0, 32'h0, 32'h0, 16'h0, 32'h0000_0111, 32'h0);
        start = 1'b1;
        @(negedge clk);
        check("R2 b2b first", ea, 32'h0000_0111);
        addr_fld = 32'h0000_0222;
        @(negedge clk);
        start = 1'b0;
        check("R2 b2b second", ea, 32'h0000_0222);
        check("R10 b2b done", {31'b0, done}, 32'd1);
        @(negedge clk);
        check("R10 b2b end", {31'b0, done}, 32'd0);

        // R1: reset during a pending indirect read
        drive(3'd4, 32'h0000_3000, 32'h0, 16'h0, 32'h0, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset req", {31'b0, mem_rd_req}, 32'd0);
        check("R1 mid reset ea", ea, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset done", {31'b0, done}, 32'd0);

        finish_run();
    end
endmodule